// File: doc/BRIEF.md
# Banked Receive Statistics Counters

This block sits on the management side of a multiport Ethernet repeater. It keeps two 32-bit receive statistics: the number of received bytes and the number of received frames. The receive path pulses `rx_byte_vld` once for each byte it accepts, with preamble and start delimiter already stripped and the FCS bytes still present. It pulses `rx_eop` once at the end of each frame. Software reaches both counters through an 8-bit register port, one byte per access.

The statistics sit in one bank of a banked address space. Software first writes the bank number through the bank-select strobe (`bank_cs`). After that, addressed accesses decode inside that bank. Each counter is read in four byte accesses, lowest byte first. The first byte read takes a snapshot of the whole counter, so the four bytes form one consistent value while counting goes on. Writes use the same byte order. A written value reaches the counter only on the last byte, and only while a management reset or repeater reset input is held.

Top module: `statreg_top`

## Requirements
- R1: A write with `bank_cs` high stores `reg_wdata` as the bank number. The counters answer only while the bank number is 0x05. In any other bank, a read of any address returns 0x00.
- R2: The byte counter, at in-bank address 0xE0, gains exactly one on each cycle in which `rx_byte_vld` is high.
- R3: The frame counter, at in-bank address 0xE1, gains exactly one on each cycle in which `rx_eop` is high.
- R4: A read accepted with `reg_rd` high returns its byte on `reg_rdata`, with `reg_rvld` high, in the following cycle. Four successive reads of one counter return bits 7:0, 15:8, 23:16 and 31:24, in that order.
- R5: A read of byte 0 captures the full 32-bit counter. Bytes 1 to 3 then come from that capture even if the counter moves in the meantime.
- R6: Each counter has its own byte pointer. The pointer advances on each access to that counter and returns to byte 0 after byte 3. It is cleared by a bank-select write and by any addressed access to another address.
- R7: Writes go low byte first. The assembled value replaces the counter when byte 3 is written, and only if `mgmt_rst` or `rptr_rst` is high. Otherwise the counter value is unchanged.
- R8: Both counters wrap from 0xFFFFFFFF to 0 without saturating.
- R9: When a committing byte-3 write and a count strobe for the same counter fall in the same cycle, the counter takes the written value and the count strobe is lost.
- R10: In bank 0x05, a read of an unmapped address returns 0x00, and a write to an unmapped address changes no counter.
- R11: After reset the bank number is 0x00, both counters are 0, `reg_rdata` is 0x00 and `reg_rvld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_rst | input | 1 | Management reset control bit; enables counter writes |
| rptr_rst | input | 1 | Repeater reset control bit; enables counter writes |
| rx_byte_vld | input | 1 | One pulse per received byte (FCS included, preamble excluded) |
| rx_eop | input | 1 | One pulse per received frame |
| bank_cs | input | 1 | Access targets the bank-select register |
| reg_addr | input | 8 | In-bank address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after the read |
| reg_rvld | output | 1 | Read data valid |

## Verification
The bench moves the byte counter by several hundred counts between the byte 0 read and the byte 1 to 3 reads. A design without the snapshot would return a torn value mixing old and new bytes. It breaks off a counter read halfway with a read of the other counter and with a bank-select write. A pointer that failed to clear would return byte 1 where byte 0 is expected. It makes a byte-3 write in the same cycle as a count strobe, which exposes a count that beats the write or adds to it. It also writes a full value with both reset controls low, drives both counters through the all-ones boundary, and touches an unmapped address and a foreign bank. A design with a loose write gate, saturation or a wide address decode would then show a changed counter or nonzero read data.

// File: rtl/statreg_pkg.sv
package statreg_pkg;

  localparam int unsigned BYTE_W = 8;

  // Byte idx of a value held in a 64-bit container
  function automatic logic [7:0] pick_byte(input logic [63:0] v, input int unsigned idx);
    return v[idx*8 +: 8];
  endfunction

  // Replace byte idx of a value held in a 64-bit container
  function automatic logic [63:0] put_byte(input logic [63:0] v, input int unsigned idx,
                                            input logic [7:0] b);
    logic [63:0] r;
    r = v;
    r[idx*8 +: 8] = b;
    return r;
  endfunction

  // Pointer step with wrap after the last byte
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned nbytes);
    return (p == nbytes - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/statreg_counter.sv
module statreg_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value
);

  // load wins over inc; natural modulo-2^W wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (inc)  value <= value + W'(1);
  end

endmodule

// File: rtl/statreg_byteport.sv
module statreg_byteport
  import statreg_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NB = W / 8,
  parameter int unsigned PW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          acc,
  input  logic          is_wr,
  input  logic          wr_ok,
  input  logic          clr,
  input  logic [7:0]    wdata,
  input  logic [W-1:0]  live,
  output logic [7:0]    rbyte,
  output logic          commit,
  output logic [W-1:0]  commit_val,
  output logic [PW-1:0] ptr
);

  logic [W-1:0] snap;
  logic [W-1:0] stage;
  logic         hit;
  logic         last;

  assign hit  = sel & acc;
  assign last = (ptr == PW'(NB - 1));

  assign rbyte      = (ptr == '0) ? pick_byte(64'(live), 0)
                                  : pick_byte(64'(snap), int'(ptr));
  assign commit     = hit & is_wr & wr_ok & last;
  assign commit_val = W'(put_byte(64'(stage), NB - 1, wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      snap  <= '0;
      stage <= '0;
    end else begin
      if (clr)      ptr <= '0;
      else if (hit) ptr <= PW'(ptr_step(int'(ptr), NB));
      if (hit && !is_wr && ptr == '0)
        snap <= live;
      if (hit && is_wr && wr_ok)
        stage <= W'(put_byte(64'(stage), int'(ptr), wdata));
    end
  end

endmodule

// File: rtl/statreg_top.sv
module statreg_top #(
  parameter int unsigned CNT_W     = 32,
  parameter logic [7:0]  BANK_ID   = 8'h05,
  parameter logic [7:0]  BASE_ADDR = 8'hE0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mgmt_rst,
  input  logic       rptr_rst,
  input  logic       rx_byte_vld,
  input  logic       rx_eop,
  input  logic       bank_cs,
  input  logic [7:0] reg_addr,
  input  logic       reg_rd,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reg_rvld
);

  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned NB      = CNT_W / 8;
  localparam int unsigned PW      = $clog2(NB);

  logic [7:0] bank_q;
  logic       bank_hit;
  logic       bank_wr_evt;
  logic       acc;
  logic       wr_ok;
  logic       unmapped_rd;
  logic [7:0] rd_byte;

  logic [NUM_CNT-1:0]            cnt_inc;
  logic [NUM_CNT-1:0]            hit_vec;
  logic [NUM_CNT-1:0]            commit;
  logic [NUM_CNT-1:0][CNT_W-1:0] commit_val;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
  logic [NUM_CNT-1:0][PW-1:0]    ptr;
  logic [NUM_CNT-1:0][7:0]       rbyte;

  assign cnt_inc     = {rx_eop, rx_byte_vld};
  assign bank_wr_evt = bank_cs & reg_wr;
  assign bank_hit    = (bank_q == BANK_ID);
  assign acc         = (reg_rd | reg_wr) & ~bank_cs;
  assign wr_ok       = mgmt_rst | rptr_rst;
  assign unmapped_rd = acc & ~reg_wr & ~(|hit_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bank_q <= '0;
    else if (bank_wr_evt) bank_q <= reg_wdata;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    assign hit_vec[g] = bank_hit & (reg_addr == 8'(BASE_ADDR + g));

    statreg_byteport #(.W(CNT_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (hit_vec[g]),
      .acc        (acc),
      .is_wr      (reg_wr),
      .wr_ok      (wr_ok),
      .clr        (bank_wr_evt | (acc & ~hit_vec[g])),
      .wdata      (reg_wdata),
      .live       (cnt_val[g]),
      .rbyte      (rbyte[g]),
      .commit     (commit[g]),
      .commit_val (commit_val[g]),
      .ptr        (ptr[g])
    );

    statreg_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (cnt_inc[g]),
      .load     (commit[g]),
      .load_val (commit_val[g]),
      .value    (cnt_val[g])
    );
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (hit_vec[i]) rd_byte = rbyte[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_rvld  <= 1'b0;
    end else begin
      reg_rvld <= reg_rd;
      if (reg_rd) reg_rdata <= bank_cs ? bank_q : rd_byte;
    end
  end

endmodule

// File: rtl/statreg_chk.sv
module statreg_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned NUM_CNT = 2,
  parameter int unsigned PW      = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            mgmt_rst,
  input logic                            rptr_rst,
  input logic                            rx_byte_vld,
  input logic                            rx_eop,
  input logic                            reg_rd,
  input logic                            bank_wr_evt,
  input logic                            unmapped_rd,
  input logic [7:0]                      reg_rdata,
  input logic                            reg_rvld,
  input logic [NUM_CNT-1:0]              commit,
  input logic [NUM_CNT-1:0][CNT_W-1:0]   commit_val,
  input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_val,
  input logic [NUM_CNT-1:0][PW-1:0]      ptr
);

  // R2
  oct_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_vld && !commit[0]) |=> cnt_val[0] == $past(cnt_val[0]) + CNT_W'(1));

  // R3
  pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop && !commit[1]) |=> cnt_val[1] == $past(cnt_val[1]) + CNT_W'(1));

  // R2
  oct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_byte_vld && !commit[0]) |=> $stable(cnt_val[0]));

  // R8
  oct_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val[0] == '1 && rx_byte_vld && !commit[0]) |=> cnt_val[0] == '0);

  // R9
  oct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[0] |=> cnt_val[0] == $past(commit_val[0]));

  // R9
  pkt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit[1] |=> cnt_val[1] == $past(commit_val[1]));

  // R7
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit) |-> (mgmt_rst || rptr_rst));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> reg_rdata == 8'h00);

  // R6
  bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr_evt |=> (ptr[0] == '0 && ptr[1] == '0));

  // R4
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvld);

endmodule

bind statreg_top statreg_chk #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mgmt_rst    (mgmt_rst),
  .rptr_rst    (rptr_rst),
  .rx_byte_vld (rx_byte_vld),
  .rx_eop      (rx_eop),
  .reg_rd      (reg_rd),
  .bank_wr_evt (bank_wr_evt),
  .unmapped_rd (unmapped_rd),
  .reg_rdata   (reg_rdata),
  .reg_rvld    (reg_rvld),
  .commit      (commit),
  .commit_val  (commit_val),
  .cnt_val     (cnt_val),
  .ptr         (ptr)
);

// File: tb/sim_statreg_top.sv
module sim_statreg_top;

  localparam logic [7:0] A_OCT = 8'hE0;
  localparam logic [7:0] A_PKT = 8'hE1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mgmt_rst, rptr_rst, rx_byte_vld, rx_eop;
  logic       bank_cs, reg_rd, reg_wr;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_rvld;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [31:0] oct_m = '0;
  logic [31:0] pkt_m = '0;

  always #10 clk = ~clk;

  statreg_top u0 (
    .clk(clk), .rst_n(rst_n), .mgmt_rst(mgmt_rst), .rptr_rst(rptr_rst),
    .rx_byte_vld(rx_byte_vld), .rx_eop(rx_eop), .bank_cs(bank_cs),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvld(reg_rvld)
  );

  // Monitor: pop expected bytes as read data comes out
  always @(negedge clk) begin
    logic [7:0] e;
    string t;
    if (rst_n && reg_rvld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: unexpected read data %h, expected no data", reg_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: read data %h, expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h, expected %h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    reg_addr = a;
    reg_rd   = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic rd32(input logic [7:0] a, input logic [31:0] v, input string t);
    for (int i = 0; i < 4; i++) rd(a, v[i*8 +: 8], t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(a, v[i*8 +: 8]);
  endtask

  task automatic setbank(input logic [7:0] b);
    bank_cs   = 1'b1;
    reg_wdata = b;
    reg_wr    = 1'b1;
    tick();
    reg_wr  = 1'b0;
    bank_cs = 1'b0;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin
      rx_byte_vld = 1'b1;
      tick();
    end
    rx_byte_vld = 1'b0;
    oct_m = oct_m + 32'(n);
  endtask

  task automatic frame_end;
    rx_eop = 1'b1;
    tick();
    rx_eop = 1'b0;
    pkt_m = pkt_m + 32'd1;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] snapv;
    rst_n = 1'b0; mgmt_rst = 1'b0; rptr_rst = 1'b0;
    rx_byte_vld = 1'b0; rx_eop = 1'b0; bank_cs = 1'b0;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    // R11 reset outputs
    chk(reg_rdata == 8'h00, "R11", 32'(reg_rdata), 32'h0);
    chk(reg_rvld == 1'b0, "R11", 32'(reg_rvld), 32'h0);
    rst_n = 1'b1;
    tick();
    // R11 bank starts at 0: counters hidden
    rd(A_OCT, 8'h00, "R11");
    setbank(8'h05);
    rd32(A_OCT, 32'h0, "R11");
    rd32(A_PKT, 32'h0, "R11");

    // R1 foreign bank hides counters
    setbank(8'h00);
    bytes(70);
    frame_end();
    rd(A_OCT, 8'h00, "R1");
    rd(A_PKT, 8'h00, "R1");
    setbank(8'h05);
    // R2 / R3 counting
    rd32(A_OCT, oct_m, "R2");
    rd32(A_PKT, pkt_m, "R3");
    bytes(5); frame_end(); frame_end();
    rd32(A_OCT, oct_m, "R2");
    rd32(A_PKT, pkt_m, "R3");

    // R7 / R4 write then byte order
    mgmt_rst = 1'b1;
    wr32(A_OCT, 32'h1234_5678);
    mgmt_rst = 1'b0;
    oct_m = 32'h1234_5678;
    rd32(A_OCT, oct_m, "R4");

    // R5 snapshot holds while counting continues
    snapv = oct_m;
    rd(A_OCT, snapv[7:0], "R5");
    bytes(300);
    rd(A_OCT, snapv[15:8], "R5");
    rd(A_OCT, snapv[23:16], "R5");
    rd(A_OCT, snapv[31:24], "R5");
    // R6 wrap back to byte 0 picks up the new value
    rd(A_OCT, oct_m[7:0], "R6");
    // R6 access elsewhere clears pointer
    rd(A_PKT, pkt_m[7:0], "R6");
    rd(A_OCT, oct_m[7:0], "R6");
    // R6 bank-select write clears pointer
    setbank(8'h05);
    rd(A_OCT, oct_m[7:0], "R6");
    rd(A_OCT, oct_m[15:8], "R6");
    setbank(8'h05);

    // R7 write with both reset controls low is ignored
    wr32(A_PKT, 32'hDEAD_BEEF);
    rd32(A_PKT, pkt_m, "R7");
    // R7 repeater reset also enables writes; R8 frame counter wraps
    rptr_rst = 1'b1;
    wr32(A_PKT, 32'hFFFF_FFFF);
    rptr_rst = 1'b0;
    pkt_m = 32'hFFFF_FFFF;
    frame_end();
    rd32(A_PKT, pkt_m, "R8");

    // R9 committing write beats a same-cycle count strobe
    mgmt_rst = 1'b1;
    wr(A_OCT, 8'h11); wr(A_OCT, 8'h0F); wr(A_OCT, 8'hC3);
    reg_addr = A_OCT; reg_wdata = 8'hA5; reg_wr = 1'b1; rx_byte_vld = 1'b1;
    tick();
    reg_wr = 1'b0; rx_byte_vld = 1'b0;
    mgmt_rst = 1'b0;
    oct_m = 32'hA5C3_0F11;
    rd32(A_OCT, oct_m, "R9");

    // R8 byte counter wraps
    mgmt_rst = 1'b1;
    wr32(A_OCT, 32'hFFFF_FFFE);
    mgmt_rst = 1'b0;
    oct_m = 32'hFFFF_FFFE;
    bytes(3);
    rd32(A_OCT, oct_m, "R8");

    // R10 unmapped address
    rd(8'hE7, 8'h00, "R10");
    rd(8'hE2, 8'h00, "R10");
    mgmt_rst = 1'b1;
    wr32(8'hE2, 32'h5555_5555);
    wr32(8'hDF, 32'hAAAA_AAAA);
    mgmt_rst = 1'b0;
    setbank(8'h05);
    rd32(A_OCT, oct_m, "R10");
    rd32(A_PKT, pkt_m, "R10");

    repeat (4) tick();
    chk(exp_q.size() == 0, "R4", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule